// File: doc/BRIEF.md
# Dual-Bus Quad SPI Byte Striper

This block connects a byte-stream engine to two quad SPI flash devices that share one serial clock and one chip select. Each device has its own 4-bit data bus, so the flash side has eight data lines. A transfer begins with a one-cycle `start` pulse. That pulse latches a bus mode, a direction, a non-zero byte count and a flag that keeps chip select asserted. Each byte is shifted out or in as two nibbles, most significant nibble first.

There are four bus modes. Lower-only and upper-only talk to a single device. Mirror drives the same byte onto both buses. Striped mode splits the stream across the buses: even-indexed bytes go to the lower device and odd-indexed bytes go to the upper device. On a striped read, the two received bytes are merged back in order, lower first and then upper. The mode is chosen per transfer. Command and address phases can therefore run mirrored with chip select kept low, and the data phase that follows can run striped.

The block also has two helpers. The first halves the logical address for the devices whenever the mode input selects striping. The second produces a busy flag from the status bytes that both devices return during a mirrored read.

Transmit and receive data use valid/ready streams. A byte moves only in a cycle where both valid and ready are high. `tx_ready` is high only while the block waits for a byte to shift out. When the producer holds `tx_valid` low, the serial clock stays low and the transfer pauses. `rx_valid` stays high, with `rx_data` unchanged, until the consumer raises `rx_ready`. No further nibbles are clocked in until the delivered bytes are taken.

Top module: `qsd_striper`

## Requirements
- R1: During and after reset, and until a start is accepted, chip select is high, the serial clock is low, neither bus is driven, `rx_valid` is low and `tx_ready` is low.
- R2: A start pulse with a byte count of zero is ignored: chip select stays high and `tx_ready` stays low.
- R3: Mode 0 (lower only) drives each written byte on the lower bus alone, and mode 1 (upper only) on the upper bus alone, high nibble first. A bus is never driven while chip select is high.
- R4: Mode 2 (mirror) drives every written byte on both buses at the same time.
- R5: Mode 3 (striped) writes bytes 0, 2, 4, ... on the lower bus and bytes 1, 3, 5, ... on the upper bus. Both halves of a pair are shifted in the same two nibble slots.
- R6: A striped write with an odd byte count sends 0xFF on the upper bus in the last slot.
- R7: Reads in modes 0, 1 and 2 deliver one byte per nibble pair, in order. Mode 0 delivers the lower device's byte, mode 1 the upper device's byte, and mode 2 the lower device's byte.
- R8: A striped read delivers the lower-bus byte and then the upper-bus byte of each slot. With an odd count, the final upper-bus byte is dropped and exactly the requested number of bytes appears.
- R9: While `rx_valid` is high and `rx_ready` low, `rx_data` holds. A transmit byte is accepted only while the serial clock is low.
- R10: Chip select stays low for the whole transfer. For a write, it rises exactly two clock cycles after the cycle that holds the final clock-high phase. If the keep flag was set at start, chip select stays low after the transfer ends.
- R11: While the mode input is 3, `dev_addr` equals `addr_in` shifted right by one. In any other mode it equals `addr_in`.
- R12: After a mirrored read byte is accepted, `flash_busy` is the OR of bit 0 of the lower-device byte and bit 0 of the upper-device byte.
- R13: Each nibble takes one low clock cycle followed by one high clock cycle of the serial clock. Input nibbles are sampled at the clock edge that ends the high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| mode | input | 2 | Bus mode: 0 lower, 1 upper, 2 mirror, 3 striped |
| is_read | input | 1 | 1 for a read transfer, 0 for a write |
| keep_cs | input | 1 | Leave chip select low after this transfer |
| byte_count | input | LEN_W | Logical bytes in the transfer |
| addr_in | input | ADDR_W | Logical flash address |
| dev_addr | output | ADDR_W | Address to send to the devices |
| tx_valid | input | 1 | Transmit byte valid |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Block can accept a transmit byte |
| rx_valid | output | 1 | Received byte valid |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Consumer accepts the received byte |
| fl_cs_n | output | 1 | Shared active-low chip select |
| fl_sclk | output | 1 | Shared serial clock |
| lo_dout | output | 4 | Lower bus output nibble |
| lo_oe | output | 1 | Lower bus output enable |
| lo_din | input | 4 | Lower bus input nibble |
| hi_dout | output | 4 | Upper bus output nibble |
| hi_oe | output | 1 | Upper bus output enable |
| hi_din | input | 4 | Upper bus input nibble |
| flash_busy | output | 1 | Combined busy bit of both devices |

## Verification
A wrong parity flag in the striping controller swaps or repeats bytes between the buses. That error shows up in the first striped slot as a wrong byte on one bus or in the receive stream. A wrong remaining-byte count makes the transfer stop early or run long. It is seen in the last slot: a missing or extra 0xFF pad, a stray `rx_valid`, or chip select rising too early or too late. Faults in the nibble phase counter show within one byte as a wrong nibble order or a clock-high phase longer than one cycle.

// File: rtl/qsd_pkg.sv
package qsd_pkg;
  typedef enum logic [1:0] {
    BUS_LO     = 2'd0,
    BUS_HI     = 2'd1,
    BUS_MIRROR = 2'd2,
    BUS_STRIPE = 2'd3
  } bus_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_DELIV,
    ST_END
  } xfer_st_e;

  localparam logic [7:0] PAD_BYTE = 8'hFF;
  localparam int         NUM_LANES = 2;
endpackage

// File: rtl/qsd_lane.sv
module qsd_lane (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       nib_low,
  input  logic       cap_hi,
  input  logic       cap_lo,
  input  logic [3:0] din,
  output logic [3:0] dout,
  output logic [7:0] rx_byte
);
  logic [7:0] tx_q;
  logic [7:0] rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load)   tx_q       <= load_byte;
      if (cap_hi) rx_q[7:4]  <= din;
      if (cap_lo) rx_q[3:0]  <= din;
    end
  end

  assign dout    = nib_low ? tx_q[3:0] : tx_q[7:4];
  assign rx_byte = rx_q;
endmodule

// File: rtl/qsd_ctrl.sv
module qsd_ctrl
  import qsd_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode_in,
  input  logic             is_read,
  input  logic             keep_cs,
  input  logic [LEN_W-1:0] byte_count,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  input  logic             rx_ready,
  input  logic [7:0]       lo_rx,
  input  logic [7:0]       hi_rx,
  output logic             cs_n,
  output logic             sclk,
  output logic             lo_oe,
  output logic             hi_oe,
  output logic             ld_lo,
  output logic             ld_hi,
  output logic [7:0]       ld_lo_byte,
  output logic [7:0]       ld_hi_byte,
  output logic             nib_low,
  output logic             cap_hi,
  output logic             cap_lo,
  output logic             stat_upd
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

  xfer_st_e         st;
  bus_mode_e        mode_q;
  logic             rd_q, keep_q, half, pair, cs_n_q;
  logic [1:0]       cnt;
  logic [LEN_W-1:0] rem, rem_after;
  logic             beat2, rem_one, in_shift, tx_hs, rx_hs;

  assign beat2     = (mode_q == BUS_STRIPE) && (rem > ONE);
  assign rem_one   = (rem == ONE);
  assign rem_after = rem - (beat2 ? TWO : ONE);
  assign in_shift  = (st == ST_SHIFT);

  assign tx_ready = (st == ST_LOAD) && !rd_q;
  assign tx_hs    = tx_ready && tx_valid;
  assign rx_valid = (st == ST_DELIV);
  assign rx_hs    = rx_valid && rx_ready;
  assign rx_data  = ((mode_q == BUS_HI) || ((mode_q == BUS_STRIPE) && half)) ? hi_rx : lo_rx;

  assign cs_n     = cs_n_q;
  assign sclk     = in_shift && cnt[0];
  assign nib_low  = cnt[1];
  assign cap_hi   = in_shift && (cnt == 2'd1);
  assign cap_lo   = in_shift && (cnt == 2'd3);
  assign lo_oe    = in_shift && !rd_q && (mode_q != BUS_HI);
  assign hi_oe    = in_shift && !rd_q && (mode_q != BUS_LO);
  assign stat_upd = rx_hs && (mode_q == BUS_MIRROR);

  always_comb begin
    ld_lo      = 1'b0;
    ld_hi      = 1'b0;
    ld_lo_byte = tx_data;
    ld_hi_byte = tx_data;
    if (tx_hs) begin
      unique case (mode_q)
        BUS_LO:     ld_lo = 1'b1;
        BUS_HI:     ld_hi = 1'b1;
        BUS_MIRROR: begin
          ld_lo = 1'b1;
          ld_hi = 1'b1;
        end
        BUS_STRIPE: begin
          if (!half) begin
            ld_lo = 1'b1;
            if (rem_one) begin
              ld_hi      = 1'b1;
              ld_hi_byte = PAD_BYTE;
            end
          end else begin
            ld_hi = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mode_q <= BUS_LO;
      rd_q   <= 1'b0;
      keep_q <= 1'b0;
      half   <= 1'b0;
      pair   <= 1'b0;
      cs_n_q <= 1'b1;
      cnt    <= '0;
      rem    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start && (byte_count != '0)) begin
            mode_q <= bus_mode_e'(mode_in);
            rd_q   <= is_read;
            keep_q <= keep_cs;
            rem    <= byte_count;
            half   <= 1'b0;
            cnt    <= '0;
            cs_n_q <= 1'b0;
            st     <= is_read ? ST_SHIFT : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (tx_hs) begin
            if ((mode_q == BUS_STRIPE) && !half && !rem_one) begin
              half <= 1'b1;
            end else begin
              half <= 1'b0;
              st   <= ST_SHIFT;
            end
          end
        end
        ST_SHIFT: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) begin
            rem  <= rem_after;
            pair <= beat2;
            half <= 1'b0;
            if (rd_q)                 st <= ST_DELIV;
            else if (rem_after == '0) st <= ST_END;
            else                      st <= ST_LOAD;
          end
        end
        ST_DELIV: begin
          if (rx_hs) begin
            if (pair && !half) begin
              half <= 1'b1;
            end else begin
              half <= 1'b0;
              st   <= (rem == '0) ? ST_END : ST_SHIFT;
            end
          end
        end
        ST_END: begin
          cs_n_q <= !keep_q;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qsd_merge.sv
module qsd_merge #(
  parameter int ADDR_W   = 24,
  parameter int BUSY_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] dev_addr,
  input  logic              stat_upd,
  input  logic [7:0]        lo_rx,
  input  logic [7:0]        hi_rx,
  output logic              busy
);
  logic lo_busy_q, hi_busy_q;

  assign dev_addr = (mode_in == qsd_pkg::BUS_STRIPE) ? (addr_in >> 1) : addr_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_busy_q <= 1'b0;
      hi_busy_q <= 1'b0;
    end else if (stat_upd) begin
      lo_busy_q <= lo_rx[BUSY_BIT];
      hi_busy_q <= hi_rx[BUSY_BIT];
    end
  end

  assign busy = lo_busy_q | hi_busy_q;
endmodule

// File: rtl/qsd_striper.sv
module qsd_striper
  import qsd_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int LEN_W    = 16,
  parameter int BUSY_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              is_read,
  input  logic              keep_cs,
  input  logic [LEN_W-1:0]  byte_count,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] dev_addr,
  input  logic              tx_valid,
  input  logic [7:0]        tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  input  logic              rx_ready,
  output logic              fl_cs_n,
  output logic              fl_sclk,
  output logic [3:0]        lo_dout,
  output logic              lo_oe,
  input  logic [3:0]        lo_din,
  output logic [3:0]        hi_dout,
  output logic              hi_oe,
  input  logic [3:0]        hi_din,
  output logic              flash_busy
);
  logic       ld_lo, ld_hi, nib_low, cap_hi, cap_lo, stat_upd;
  logic [7:0] ld_lo_byte, ld_hi_byte;
  logic       lane_ld   [NUM_LANES];
  logic [7:0] lane_byte [NUM_LANES];
  logic [3:0] lane_din  [NUM_LANES];
  logic [3:0] lane_dout [NUM_LANES];
  logic [7:0] lane_rx   [NUM_LANES];

  assign lane_ld[0]   = ld_lo;
  assign lane_ld[1]   = ld_hi;
  assign lane_byte[0] = ld_lo_byte;
  assign lane_byte[1] = ld_hi_byte;
  assign lane_din[0]  = lo_din;
  assign lane_din[1]  = hi_din;
  assign lo_dout      = lane_dout[0];
  assign hi_dout      = lane_dout[1];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    qsd_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (lane_ld[g]),
      .load_byte (lane_byte[g]),
      .nib_low   (nib_low),
      .cap_hi    (cap_hi),
      .cap_lo    (cap_lo),
      .din       (lane_din[g]),
      .dout      (lane_dout[g]),
      .rx_byte   (lane_rx[g])
    );
  end

  qsd_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_in    (mode),
    .is_read    (is_read),
    .keep_cs    (keep_cs),
    .byte_count (byte_count),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .lo_rx      (lane_rx[0]),
    .hi_rx      (lane_rx[1]),
    .cs_n       (fl_cs_n),
    .sclk       (fl_sclk),
    .lo_oe      (lo_oe),
    .hi_oe      (hi_oe),
    .ld_lo      (ld_lo),
    .ld_hi      (ld_hi),
    .ld_lo_byte (ld_lo_byte),
    .ld_hi_byte (ld_hi_byte),
    .nib_low    (nib_low),
    .cap_hi     (cap_hi),
    .cap_lo     (cap_lo),
    .stat_upd   (stat_upd)
  );

  qsd_merge #(.ADDR_W(ADDR_W), .BUSY_BIT(BUSY_BIT)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_in  (mode),
    .addr_in  (addr_in),
    .dev_addr (dev_addr),
    .stat_upd (stat_upd),
    .lo_rx    (lane_rx[0]),
    .hi_rx    (lane_rx[1]),
    .busy     (flash_busy)
  );
endmodule

// File: rtl/qsd_striper_chk.sv
module qsd_striper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       fl_cs_n,
  input logic       fl_sclk,
  input logic       lo_oe,
  input logic       hi_oe
);
  // R9: a stalled receive byte stays put
  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R9: transmit bytes are taken only with the serial clock low
  a_r9_tx_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |-> !fl_sclk);

  // R10: the serial clock only pulses inside chip select
  a_r10_sclk_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    fl_sclk |-> !fl_cs_n);

  // R13: each clock-high phase lasts one cycle
  a_r13_high_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fl_sclk |=> !fl_sclk);

  // R3: no bus is driven outside chip select
  a_r3_drive_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_oe || hi_oe) |-> !fl_cs_n);
endmodule

bind qsd_striper qsd_striper_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_data  (rx_data),
  .fl_cs_n  (fl_cs_n),
  .fl_sclk  (fl_sclk),
  .lo_oe    (lo_oe),
  .hi_oe    (hi_oe)
);

// File: tb/test_qsd_striper.sv
module test_qsd_striper;
  localparam int ADDR_W = 24;
  localparam int LEN_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [1:0]        mode;
  logic              is_read, keep_cs;
  logic [LEN_W-1:0]  byte_count;
  logic [ADDR_W-1:0] addr_in, dev_addr;
  logic              tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0]        tx_data, rx_data;
  logic              fl_cs_n, fl_sclk, lo_oe, hi_oe, flash_busy;
  logic [3:0]        lo_dout, hi_dout, lo_din, hi_din;

  always #5 clk = ~clk;

  qsd_striper #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_qsd_striper (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .is_read(is_read),
    .keep_cs(keep_cs), .byte_count(byte_count), .addr_in(addr_in),
    .dev_addr(dev_addr), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .fl_cs_n(fl_cs_n), .fl_sclk(fl_sclk),
    .lo_dout(lo_dout), .lo_oe(lo_oe), .lo_din(lo_din), .hi_dout(hi_dout),
    .hi_oe(hi_oe), .hi_din(hi_din), .flash_busy(flash_busy)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] f(input int j);
    return 8'(j * 7 + 3);
  endfunction

  // flash model and bus monitor
  logic [7:0] lo_beat [16];
  logic [7:0] hi_beat [16];
  logic [7:0] lo_cap  [16];
  logic [7:0] hi_cap  [16];
  logic [7:0] got     [16];
  logic [3:0] lo_hold, hi_hold;
  int nib_idx, lo_n, hi_n, lo_nib, hi_nib, high_cycles, cycle, last_high, cs_rise;
  bit seen_high, cs_prev = 1'b1;

  assign lo_din = nib_idx[0] ? lo_beat[(nib_idx >> 1) & 15][3:0] : lo_beat[(nib_idx >> 1) & 15][7:4];
  assign hi_din = nib_idx[0] ? hi_beat[(nib_idx >> 1) & 15][3:0] : hi_beat[(nib_idx >> 1) & 15][7:4];

  always @(negedge clk) begin
    cycle++;
    if (!fl_cs_n) begin
      if (fl_sclk) begin
        seen_high = 1'b1;
        high_cycles++;
        last_high = cycle;
        if (lo_oe) begin
          if (lo_nib % 2 == 0) lo_hold = lo_dout;
          else begin lo_cap[lo_n & 15] = {lo_hold, lo_dout}; lo_n++; end
          lo_nib++;
        end
        if (hi_oe) begin
          if (hi_nib % 2 == 0) hi_hold = hi_dout;
          else begin hi_cap[hi_n & 15] = {hi_hold, hi_dout}; hi_n++; end
          hi_nib++;
        end
      end else if (seen_high) begin
        nib_idx++;
        seen_high = 1'b0;
      end
    end
    if (fl_cs_n && !cs_prev) cs_rise = cycle;
    cs_prev = fl_cs_n;
  end

  task automatic clear_model();
    nib_idx = 0; lo_n = 0; hi_n = 0; lo_nib = 0; hi_nib = 0;
    high_cycles = 0; seen_high = 1'b0; cs_rise = 0; last_high = 0;
  endtask

  int extra_rx;

  task automatic run(input logic [1:0] m, input bit rd, input int n, input bit keep);
    int j = 0;
    int cyc = 0;
    clear_model();
    extra_rx = 0;
    @(negedge clk);
    mode = m; is_read = rd; byte_count = LEN_W'(n); keep_cs = keep; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (j < n && cyc < 500) begin
      if (!rd) begin
        tx_valid = (cyc % 5 != 4);
        tx_data  = f(j);
      end else begin
        rx_ready = (cyc % 3 != 1);
      end
      #1;
      if (!rd && tx_valid && tx_ready) j++;
      if (rd && rx_valid) begin
        if (rx_ready) begin
          got[j & 15] = rx_data;
          j++;
        end else begin
          logic [7:0] held;
          held = rx_data;
          @(negedge clk); cyc++;
          chk(rx_valid && (rx_data == held), "R9 rx hold", int'(rx_data), int'(held));
          continue;
        end
      end
      @(negedge clk);
      cyc++;
    end
    tx_valid = 1'b0;
    rx_ready = 1'b1;
    for (int w = 0; w < 30; w++) begin
      @(negedge clk);
      if (rx_valid) extra_rx++;
      if (!keep && fl_cs_n) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // table: {mode[1:0], is_read, count[4:0]}
  localparam logic [7:0] VEC [9] = '{
    {2'd0, 1'b0, 5'd3}, {2'd1, 1'b0, 5'd2}, {2'd2, 1'b0, 5'd2},
    {2'd3, 1'b0, 5'd4}, {2'd3, 1'b0, 5'd3}, {2'd0, 1'b1, 5'd2},
    {2'd1, 1'b1, 5'd2}, {2'd2, 1'b1, 5'd2}, {2'd3, 1'b1, 5'd5}
  };

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 2'd0; is_read = 1'b0; keep_cs = 1'b0;
    byte_count = '0; addr_in = '0; tx_valid = 1'b0; tx_data = '0; rx_ready = 1'b1;
    for (int k = 0; k < 16; k++) begin lo_beat[k] = '0; hi_beat[k] = '0; end
    clear_model();
    repeat (3) @(negedge clk);
    chk(fl_cs_n == 1'b1 && fl_sclk == 1'b0, "R1 cs/sclk in reset", {fl_cs_n, fl_sclk}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!lo_oe && !hi_oe && !rx_valid && !tx_ready && fl_cs_n, "R1 idle after reset",
        {lo_oe, hi_oe, rx_valid, tx_ready, fl_cs_n}, 5'b00001);

    // R2: zero count is ignored
    mode = 2'd3; byte_count = '0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      bit bad = 1'b0;
      for (int k = 0; k < 8; k++) begin
        if (!fl_cs_n || tx_ready) bad = 1'b1;
        @(negedge clk);
      end
      chk(!bad, "R2 zero count ignored", bad, 0);
    end

    // table walk
    for (int v = 0; v < 9; v++) begin
      logic [1:0] m;
      bit rd;
      int n;
      m = VEC[v][7:6]; rd = VEC[v][5]; n = int'(VEC[v][4:0]);
      for (int k = 0; k < 16; k++) begin
        lo_beat[k] = (m == 2'd3) ? f(2 * k) : f(k);
        hi_beat[k] = (m == 2'd3) ? f(2 * k + 1) : (f(k) ^ 8'h5A);
      end
      run(m, rd, n, 1'b0);
      if (!rd) begin
        int exp_lo, exp_hi;
        exp_lo = (m == 2'd1) ? 0 : ((m == 2'd3) ? (n + 1) / 2 : n);
        exp_hi = (m == 2'd0) ? 0 : ((m == 2'd3) ? (n + 1) / 2 : n);
        chk(lo_n == exp_lo && hi_n == exp_hi, (m < 2) ? "R3 lane byte counts" :
            (m == 2) ? "R4 lane byte counts" : "R5 lane byte counts",
            lo_n * 256 + hi_n, exp_lo * 256 + exp_hi);
        for (int k = 0; k < exp_lo; k++)
          chk(lo_cap[k] == ((m == 2'd3) ? f(2 * k) : f(k)),
              (m == 2) ? "R4 lower byte" : (m == 3) ? "R5 lower even byte" : "R3 lower byte",
              int'(lo_cap[k]), int'((m == 2'd3) ? f(2 * k) : f(k)));
        for (int k = 0; k < exp_hi; k++) begin
          logic [7:0] e;
          e = (m == 2'd3) ? ((2 * k + 1 < n) ? f(2 * k + 1) : 8'hFF) : f(k);
          chk(hi_cap[k] == e, (m == 3 && 2 * k + 1 >= n) ? "R6 pad byte" :
              (m == 3) ? "R5 upper odd byte" : (m == 2) ? "R4 upper byte" : "R3 upper byte",
              int'(hi_cap[k]), int'(e));
        end
        chk(cs_rise - last_high == 2, "R10 cs release timing", cs_rise - last_high, 2);
      end else begin
        for (int k = 0; k < n; k++) begin
          logic [7:0] e;
          e = (m == 2'd1) ? (f(k) ^ 8'h5A) : f(k);
          chk(got[k] == e, (m == 3) ? "R8 merged read byte" : "R7 read byte",
              int'(got[k]), int'(e));
        end
        chk(extra_rx == 0, (m == 3) ? "R8 no extra byte" : "R7 no extra byte", extra_rx, 0);
      end
    end

    // R13: one byte in lower mode gives two clock-high cycles
    run(2'd0, 1'b0, 1, 1'b0);
    chk(high_cycles == 2, "R13 clock phases per byte", high_cycles, 2);

    // R10: keep flag holds chip select, next striped transfer releases it
    run(2'd2, 1'b0, 1, 1'b1);
    chk(fl_cs_n == 1'b0, "R10 keep cs low", fl_cs_n, 0);
    run(2'd3, 1'b0, 2, 1'b0);
    chk(fl_cs_n == 1'b1, "R10 cs released", fl_cs_n, 1);
    chk(lo_cap[0] == f(0) && hi_cap[0] == f(1), "R5 striped after mirror",
        {lo_cap[0], hi_cap[0]}, {f(0), f(1)});

    // R11: address halving
    @(negedge clk);
    addr_in = 24'h123457; mode = 2'd3; #1;
    chk(dev_addr == 24'h091A2B, "R11 striped address", int'(dev_addr), 24'h091A2B);
    mode = 2'd0; #1;
    chk(dev_addr == 24'h123457, "R11 single address", int'(dev_addr), 24'h123457);

    // R12: combined busy
    lo_beat[0] = 8'h00; hi_beat[0] = 8'h01;
    run(2'd2, 1'b1, 1, 1'b0);
    chk(flash_busy == 1'b1, "R12 upper busy", flash_busy, 1);
    lo_beat[0] = 8'h02; hi_beat[0] = 8'h80;
    run(2'd2, 1'b1, 1, 1'b0);
    chk(flash_busy == 1'b0, "R12 none busy", flash_busy, 0);
    lo_beat[0] = 8'h01; hi_beat[0] = 8'h00;
    run(2'd2, 1'b1, 1, 1'b0);
    chk(flash_busy == 1'b1, "R12 lower busy", flash_busy, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule